// File: doc/BRIEF.md
# Four-Mode Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that sits on a simple register bus. It has two bus locations. The data location is shared: a write hands a byte to the transmitter and starts a frame, and a read returns the last byte the receiver accepted. The control location holds the frame mode, the receive enable, the outgoing ninth bit, the incoming ninth bit and two sticky completion flags. The interrupt request is raised while either flag is set.

The bit timing comes from outside. One enable input advances the transmitter by one bit per pulse. A second enable input runs at sixteen times the bit rate and drives the receiver. The receiver finds the start bit with a zero detector and checks it again at mid-bit to reject glitches. It then samples each following bit at the centre of its period into a nine-bit shifter that is preset to all ones. Once the last bit is in, the received byte moves to a holding register, so the next frame can arrive while software is still reading.

Top module: `quad_mode_uart`

## Requirements
- R1: After reset the serial output is high and the interrupt is low. Both bus locations read 0x00.
- R2: Mode 1 sends a 10-bit frame: a low start bit, then 8 data bits LSB first, then a high stop bit. Mode 0 sends a 9-bit frame: start, the low 7 data bits LSB first, stop.
- R3: Modes 2 and 3 send 11-bit frames: start, 8 data bits LSB first, a ninth bit, then stop. In mode 2 the ninth bit is control bit 3. In mode 3 it is the XOR of the 8 data bits (even parity).
- R4: A write to the data location (address 0) while the transmitter is idle starts a frame. The first transmit enable after the write drives the start bit. Each later enable drives the next bit. The enable that follows the stop bit ends the frame and sets the transmit-done flag (control bit 1). The serial output is high whenever no frame is in progress.
- R5: A write to the data location while a frame is in progress is ignored and starts no second frame.
- R6: The receiver starts when it sees a low input on a receive enable pulse. It checks the line again 8 enables later and drops the frame if the line is high there. Each further bit is sampled 16 enables after the previous sample.
- R7: When the last bit of a frame is sampled, the data byte moves to the holding register (read at address 0) and the receive-done flag (control bit 0) is set. Control bit 2 takes the received stop bit in modes 0 and 1, or the received ninth bit in modes 2 and 3. In mode 0, bit 7 of the held byte is 0.
- R8: A frame that completes while the receive-done flag is set is dropped. The holding register and control bit 2 keep their values.
- R9: While receive enable (control bit 4) is 0, the receiver stays idle and nothing on the input is received.
- R10: Both flags stay set until a control write clears them. When hardware sets a flag in the same cycle as a control write that clears it, the flag ends up set.
- R11: The interrupt output is high exactly when either flag is set.
- R12: Transmission and reception run at the same time without disturbing each other.
- R13: Writes to control bit 2 are ignored. Reads have no side effects. The control location reads as {mode[1:0] in bits 7:6, 0, rx enable, tx ninth, rx ninth, tx done, rx done}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | 0 selects data, 1 selects control |
| busWr | input | 1 | Write strobe for one cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the selected location |
| txTick | input | 1 | One pulse per transmitted bit period |
| rxTick | input | 1 | Sixteen pulses per received bit period |
| rxIn | input | 1 | Serial input |
| txOut | output | 1 | Serial output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a software write that clears the transmit-done flag in the same cycle as the enable pulse that ends a frame. To reach it, the bench stops the free-running transmit enable, issues the bit pulses by hand, and lines the clearing write up with the final pulse. Receive overrun and glitch rejection are reached by driving whole frames onto the input without clearing the flag, and by a low pulse shorter than half a bit. A behavioural model that holds the frame bits in queues is compared with the design on every cycle.

// File: rtl/qmu_pkg.sv
package qmu_pkg;
  localparam int BYTE_W    = 8;
  localparam int FRAME_MAX = 11;
  localparam int SHIFT_W   = BYTE_W + 1;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  localparam int CB_RXDONE = 0;
  localparam int CB_TXDONE = 1;
  localparam int CB_RXNINE = 2;
  localparam int CB_TXNINE = 3;
  localparam int CB_RXEN   = 4;
  localparam int CB_MODELO = 6;

  typedef enum logic [1:0] {
    MODE_SHORT  = 2'd0,
    MODE_BYTE   = 2'd1,
    MODE_NINE   = 2'd2,
    MODE_PARITY = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rxState_e;

  typedef struct packed {
    logic              loadTx;
    logic [BYTE_W-1:0] txByte;
    mode_e             mode;
    logic              ninthTx;
    logic              rxEnable;
    logic              holdBusy;
  } ctl2dp_t;

  typedef struct packed {
    logic txFinished;
    logic rxCommit;
    logic ninthRx;
  } dp2ctl_t;
endpackage

// File: rtl/qmu_ctrl.sv
module qmu_ctrl
  import qmu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic              irq,
  input  logic [BYTE_W-1:0] holdByte,
  input  logic              txBusy,
  input  dp2ctl_t           stat,
  output ctl2dp_t           cmd
);
  mode_e modeQ;
  logic  rxEnQ, tx9Q, rx9Q, txDoneQ, rxDoneQ;
  logic  ctrlWr, dataWr;
  logic  [BYTE_W-1:0] ctrlImage;
  logic  unusedWdata;

  assign ctrlWr      = busWr & busAddr;
  assign dataWr      = busWr & ~busAddr;
  assign unusedWdata = ^{busWdata[5], busWdata[CB_RXNINE]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_SHORT;
      rxEnQ   <= 1'b0;
      tx9Q    <= 1'b0;
      rx9Q    <= 1'b0;
      txDoneQ <= 1'b0;
      rxDoneQ <= 1'b0;
    end else begin
      if (ctrlWr) begin
        modeQ   <= mode_e'(busWdata[CB_MODELO+1:CB_MODELO]);
        rxEnQ   <= busWdata[CB_RXEN];
        tx9Q    <= busWdata[CB_TXNINE];
        txDoneQ <= busWdata[CB_TXDONE];
        rxDoneQ <= busWdata[CB_RXDONE];
      end
      // hardware events override a same-cycle software write
      if (stat.txFinished) txDoneQ <= 1'b1;
      if (stat.rxCommit) begin
        rxDoneQ <= 1'b1;
        rx9Q    <= stat.ninthRx;
      end
    end
  end

  always_comb begin
    ctrlImage                        = '0;
    ctrlImage[CB_MODELO+1:CB_MODELO] = modeQ;
    ctrlImage[CB_RXEN]               = rxEnQ;
    ctrlImage[CB_TXNINE]             = tx9Q;
    ctrlImage[CB_RXNINE]             = rx9Q;
    ctrlImage[CB_TXDONE]             = txDoneQ;
    ctrlImage[CB_RXDONE]             = rxDoneQ;
  end

  assign busRdata = busAddr ? ctrlImage : holdByte;
  assign irq      = txDoneQ | rxDoneQ;

  always_comb begin
    cmd.loadTx   = dataWr & ~txBusy;
    cmd.txByte   = busWdata;
    cmd.mode     = modeQ;
    cmd.ninthTx  = tx9Q;
    cmd.rxEnable = rxEnQ;
    cmd.holdBusy = rxDoneQ;
  end
endmodule

// File: rtl/qmu_datapath.sv
module qmu_datapath
  import qmu_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txTick,
  input  logic              rxTick,
  input  logic              rxIn,
  input  ctl2dp_t           cmd,
  output dp2ctl_t           stat,
  output logic              txOut,
  output logic              txBusy,
  output logic              rxIdle,
  output logic [BYTE_W-1:0] holdByte
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] SUB_MID  = CNT_W'(HALF - 1);

  // ---------------- transmitter ----------------
  logic [FRAME_MAX-1:0] frameVec, txShift;
  logic [LEN_W-1:0]     frameLen, txLeft;

  always_comb begin
    frameVec = '1;
    frameLen = LEN_W'(FRAME_MAX);
    unique case (cmd.mode)
      MODE_SHORT: begin
        frameVec[BYTE_W:0] = {1'b1, cmd.txByte[BYTE_W-2:0], 1'b0};
        frameLen           = LEN_W'(BYTE_W + 1);
      end
      MODE_BYTE: begin
        frameVec[BYTE_W+1:0] = {1'b1, cmd.txByte, 1'b0};
        frameLen             = LEN_W'(BYTE_W + 2);
      end
      MODE_NINE:   frameVec = {1'b1, cmd.ninthTx, cmd.txByte, 1'b0};
      MODE_PARITY: frameVec = {1'b1, ^cmd.txByte, cmd.txByte, 1'b0};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txOut   <= 1'b1;
      txShift <= '1;
      txLeft  <= '0;
    end else if (cmd.loadTx) begin
      txBusy  <= 1'b1;
      txShift <= frameVec;
      txLeft  <= frameLen;
    end else if (txBusy && txTick) begin
      if (txLeft != '0) begin
        txOut   <= txShift[0];
        txShift <= {1'b1, txShift[FRAME_MAX-1:1]};
        txLeft  <= txLeft - 1'b1;
      end else begin
        txBusy <= 1'b0;
      end
    end
  end

  assign stat.txFinished = txBusy & txTick & (txLeft == '0);

  // ---------------- receiver ----------------
  rxState_e           rxState;
  mode_e              rxMode;
  logic [CNT_W-1:0]   sub;
  logic [3:0]         idx, lastIdx;
  logic [SHIFT_W-1:0] rxShift, shNext, finalVec;
  logic [BYTE_W-1:0]  dataOut;
  logic               sampleNow, lastNow, shiftThis, ninthMode;

  assign ninthMode = (rxMode == MODE_NINE) || (rxMode == MODE_PARITY);

  always_comb begin
    unique case (rxMode)
      MODE_SHORT: lastIdx = 4'(BYTE_W - 1);
      MODE_BYTE:  lastIdx = 4'(BYTE_W);
      default:    lastIdx = 4'(BYTE_W + 1);
    endcase
  end

  assign sampleNow = rxTick && (rxState == RX_BITS) && (sub == SUB_LAST);
  assign lastNow   = sampleNow && (idx == lastIdx);
  assign shiftThis = !(ninthMode && idx == lastIdx);
  assign shNext    = {rxIn, rxShift[SHIFT_W-1:1]};
  assign finalVec  = ninthMode ? rxShift : shNext;
  assign dataOut   = (rxMode == MODE_SHORT) ? {1'b0, finalVec[BYTE_W-1:1]}
                                            : finalVec[BYTE_W-1:0];

  assign stat.rxCommit = lastNow && cmd.rxEnable && !cmd.holdBusy;
  assign stat.ninthRx  = finalVec[SHIFT_W-1];
  assign rxIdle        = (rxState == RX_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxMode  <= MODE_SHORT;
      sub     <= '0;
      idx     <= '0;
      rxShift <= '1;
    end else if (!cmd.rxEnable) begin
      rxState <= RX_IDLE;
    end else if (rxTick) begin
      unique case (rxState)
        RX_IDLE: if (!rxIn) begin
          rxState <= RX_START;
          sub     <= '0;
          rxShift <= '1;
          rxMode  <= cmd.mode;
        end
        RX_START: begin
          if (sub == SUB_MID) begin
            sub     <= '0;
            idx     <= '0;
            rxState <= rxIn ? RX_IDLE : RX_BITS;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        RX_BITS: begin
          sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
          if (sub == SUB_LAST) begin
            if (shiftThis) rxShift <= shNext;
            idx <= idx + 1'b1;
            if (idx == lastIdx) rxState <= RX_IDLE;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              holdByte <= '0;
    else if (stat.rxCommit) holdByte <= dataOut;
  end
endmodule

// File: rtl/quad_mode_uart.sv
module quad_mode_uart
  import qmu_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              txTick,
  input  logic              rxTick,
  input  logic              rxIn,
  output logic              txOut,
  output logic              irq
);
  ctl2dp_t           cmd;
  dp2ctl_t           stat;
  logic              txBusy, rxIdle;
  logic [BYTE_W-1:0] holdByte;

  qmu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .holdByte(holdByte), .txBusy(txBusy), .stat(stat), .cmd(cmd)
  );

  qmu_datapath #(.OVERSAMPLE(OVERSAMPLE)) dp_i (
    .clk(clk), .rstN(rstN), .txTick(txTick), .rxTick(rxTick), .rxIn(rxIn),
    .cmd(cmd), .stat(stat), .txOut(txOut), .txBusy(txBusy),
    .rxIdle(rxIdle), .holdByte(holdByte)
  );
endmodule

// File: rtl/qmu_checker.sv
module qmu_checker
  import qmu_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    busAddr,
  input logic    busWr,
  input logic    txOut,
  input logic    irq,
  input logic    txBusy,
  input logic    rxIdle,
  input ctl2dp_t cmd,
  input dp2ctl_t stat
);
  assert_rxdone_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmd.holdBusy && !(busWr && busAddr) |=> cmd.holdBusy);

  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.holdBusy |-> !stat.rxCommit);

  assert_idle_line_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txOut);

  assert_finish_raises_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    stat.txFinished |=> irq);

  assert_disabled_rx_idles_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.rxEnable |=> rxIdle);
endmodule

bind quad_mode_uart qmu_checker chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .txOut(txOut),
  .irq(irq), .txBusy(txBusy), .rxIdle(rxIdle), .cmd(cmd), .stat(stat)
);

// File: tb/quad_mode_uart_tb_top.sv
module quad_mode_uart_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       busAddr = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  wire  [7:0] busRdata;
  wire        txOut, irq, txTick;
  logic       rxTick = 1'b0, txGen = 1'b0, manTx = 1'b0, autoTx = 1'b1;
  logic       rxLine = 1'b1;
  int         phase = 0;
  int         vectors = 0, miscompares = 0;

  assign txTick = autoTx ? txGen : manTx;

  always @(negedge clk) begin
    phase++;
    txGen  <= (phase % 4 == 0);
    rxTick <= (phase % 2 == 0);
  end

  quad_mode_uart dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .txTick(txTick),
    .rxTick(rxTick), .rxIn(rxLine), .txOut(txOut), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  int   mMode;
  bit   mRxEn, mTx9, mRx9, mTxDone, mRxDone, mTxBusy, mTxOut, mRxAct;
  byte  mHold;
  bit   txq[$];
  bit   rxb[$];
  int   rxCnt, rxMode;
  bit   oldBusy, oldRxEn, oldRxDone, txFin, commit, n9;
  byte  cd;

  function automatic int rxBits(int m);
    return (m == 0) ? 8 : (m == 1) ? 9 : 10;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mRxEn = 0; mTx9 = 0; mRx9 = 0; mTxDone = 0; mRxDone = 0;
      mTxBusy = 0; mTxOut = 1; mRxAct = 0; mHold = 0;
      txq.delete(); rxb.delete();
    end else begin
      oldBusy = mTxBusy; oldRxEn = mRxEn; oldRxDone = mRxDone;
      txFin = 0; commit = 0;
      if (oldBusy && txTick) begin
        if (txq.size() > 0) mTxOut = txq.pop_front();
        else begin mTxBusy = 0; txFin = 1; end
      end
      if (busWr && !busAddr && !oldBusy) begin
        txq.delete();
        txq.push_back(1'b0);
        for (int i = 0; i < ((mMode == 0) ? 7 : 8); i++) txq.push_back(busWdata[i]);
        if (mMode == 2) txq.push_back(mTx9);
        if (mMode == 3) txq.push_back(^busWdata);
        txq.push_back(1'b1);
        mTxBusy = 1;
      end
      if (!oldRxEn) mRxAct = 0;
      else if (rxTick) begin
        if (!mRxAct) begin
          if (!rxLine) begin mRxAct = 1; rxCnt = 0; rxb.delete(); rxMode = mMode; end
        end else begin
          rxCnt++;
          if (rxCnt == 8) begin
            if (rxLine) mRxAct = 0;
          end else if (rxCnt > 8 && (rxCnt - 8) % 16 == 0) begin
            rxb.push_back(rxLine);
            if (rxb.size() == rxBits(rxMode)) begin
              mRxAct = 0;
              if (!oldRxDone) begin
                commit = 1;
                cd = 0;
                for (int i = 0; i < ((rxMode == 0) ? 7 : 8); i++) cd[i] = rxb[i];
                n9 = (rxMode == 0) ? rxb[7] : rxb[8];
              end
            end
          end
        end
      end
      if (busWr && busAddr) begin
        mMode = int'(busWdata[7:6]); mRxEn = busWdata[4]; mTx9 = busWdata[3];
        mTxDone = busWdata[1]; mRxDone = busWdata[0];
      end
      if (txFin) mTxDone = 1;
      if (commit) begin mRxDone = 1; mRx9 = n9; mHold = cd; end
    end
  end

  function automatic logic [7:0] expRd();
    return busAddr ? {2'(mMode), 1'b0, mRxEn, mTx9, mRx9, mTxDone, mRxDone} : mHold;
  endfunction

  always @(posedge clk) begin
    #2;
    if (rstN) begin
      vectors++;
      if (txOut !== mTxOut) begin
        miscompares++;
        $display("FAIL R2/R3/R5/R12 txOut act=%0b exp=%0b t=%0t", txOut, mTxOut, $time);
      end
      if (irq !== (mTxDone | mRxDone)) begin
        miscompares++;
        $display("FAIL R11 irq act=%0b exp=%0b t=%0t", irq, mTxDone | mRxDone, $time);
      end
      if (busRdata !== expRd()) begin
        miscompares++;
        $display("FAIL R7/R13 rdata act=%02h exp=%02h t=%0t", busRdata, expRd(), $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(bit a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic sendRx(int mode, logic [7:0] d, bit ninth);
    logic [10:0] f;
    int len;
    f = '1;
    case (mode)
      0:       begin f[8:0] = {1'b1, d[6:0], 1'b0}; len = 9;  end
      1:       begin f[9:0] = {1'b1, d, 1'b0};      len = 10; end
      default: begin f = {1'b1, ninth, d, 1'b0};    len = 11; end
    endcase
    for (int i = 0; i < len; i++) begin
      rxLine = f[i];
      cyc(32);
    end
    rxLine = 1'b1;
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all requirements) act=running exp=finished");
    finishRun();
  end

  logic [7:0] v;
  initial begin
    cyc(5);
    rstN = 1'b1;
    // R1: reset state
    rd(1, v); check("R1 ctrl after reset", v, 8'h00);
    rd(0, v); check("R1 data after reset", v, 8'h00);
    check("R1 txOut idle", txOut, 1); check("R1 irq low", irq, 0);

    // R4: mode 1 frame, done flag
    wr(1, 8'h50); wr(0, 8'hA5); cyc(2);
    check("R4 irq low during frame", irq, 0);
    cyc(60);
    rd(1, v); check("R4 tx done bit1", v[1], 1);
    check("R11 irq with tx done", irq, 1);

    // R5: write during frame ignored
    wr(1, 8'h50); wr(0, 8'h3C); cyc(6); wr(0, 8'hFF); cyc(50);
    wr(1, 8'h50); cyc(60);
    rd(1, v); check("R5 no second frame", v[1], 0);
    check("R11 irq low after clear", irq, 0);

    // R6/R7: mode 1 receive
    sendRx(1, 8'h5A, 0); cyc(20);
    rd(0, v); check("R7 held byte", v, 8'h5A);
    rd(1, v); check("R7 rx done bit0", v[0], 1); check("R7 stop in bit2", v[2], 1);

    // R10 sticky, R8 overrun
    cyc(50);
    rd(1, v); check("R10 rx done sticky", v[0], 1);
    sendRx(1, 8'h33, 0); cyc(20);
    rd(0, v); check("R8 overrun keeps byte", v, 8'h5A);

    // R13: rx9 not writable, reads without side effects
    wr(1, 8'h50);
    rd(1, v); check("R13 rx9 write ignored", v[2], 1);
    rd(0, v); rd(0, v); check("R13 repeated read", v, 8'h5A);

    // R6: glitch rejection
    @(negedge clk); rxLine = 1'b0; cyc(6); rxLine = 1'b1; cyc(400);
    rd(1, v); check("R6 glitch rejected", v[0], 0);

    // R9: receiver disabled
    wr(1, 8'h40); sendRx(1, 8'h77, 0); cyc(20);
    rd(1, v); check("R9 no rx when disabled", v[0], 0);
    rd(0, v); check("R9 hold unchanged", v, 8'h5A);

    // R12 + R3: mode 2 full duplex
    wr(1, 8'h98);
    fork
      wr(0, 8'hC3);
      sendRx(2, 8'h96, 0);
    join
    cyc(20);
    rd(0, v); check("R12 rx byte during tx", v, 8'h96);
    rd(1, v); check("R12 both flags", v[1:0], 2'b11); check("R7 ninth bit 0", v[2], 0);

    // R3: mode 3 parity transmit, ninth receive
    wr(1, 8'hD0); wr(0, 8'h07); sendRx(3, 8'h0F, 1); cyc(20);
    rd(0, v); check("R3 mode3 rx byte", v, 8'h0F);
    rd(1, v); check("R7 ninth bit 1", v[2], 1);

    // R2: mode 0 short frames
    wr(1, 8'h10); wr(0, 8'hB3); sendRx(0, 8'hAA, 0); cyc(20);
    rd(0, v); check("R2 mode0 rx 7 bits", v, 8'h2A);
    rd(1, v); check("R7 mode0 stop bit", v[2], 1);

    // R10: hardware set wins over same-cycle clear
    wr(1, 8'h50);
    @(negedge clk); autoTx = 1'b0;
    wr(0, 8'h81);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); manTx = 1'b1;
      @(negedge clk); manTx = 1'b0;
    end
    rd(1, v); check("R4 not done before final tick", v[1], 0);
    @(negedge clk); manTx = 1'b1; busAddr = 1'b1; busWr = 1'b1; busWdata = 8'h50;
    @(negedge clk); manTx = 1'b0; busWr = 1'b0;
    rd(1, v); check("R10 set beats clear", v[1], 1);
    autoTx = 1'b1;
    cyc(10);
    finishRun();
  end
endmodule